// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits beside the latches of a five-stage in-order pipeline and fills in source operands whose values were not yet available when they were read. Each operand descriptor carries a register index, a value and a "resolved" flag. Two ALU operands (the first and second source) wait in the decode/execute latch. A store-data operand waits in the execute/memory latch. A producer counts only when its latch is occupied, the instruction in it writes a register, and its destination index equals the operand's index. Register 0 is never forwarded.

The ALU operands look at both downstream producers. A hit in the execute/memory latch wins over a hit in the memory/writeback latch, because it holds the younger result. The store-data operand can only be fed from the memory/writeback latch. An operand that is already resolved passes through untouched. An operand that finds no producer leaves the block still unresolved. The logic is purely combinational. The surrounding pipeline captures the outputs into its latches on the next clock edge as it advances.

Presence of a forwarded value is carried by the resolved flag and never by the data itself, so a result of zero is forwarded like any other. There is no data stream and no handshake here: every pin is a plain level signal sampled within the cycle.

Top module: `opnd_bypass`

## Requirements
- R1: An unresolved first ALU operand whose index matches an occupied, register-writing execute/memory latch leaves with that latch's result and resolved=1.
- R2: The second ALU operand is examined with the same rules as the first, independently of it.
- R3: When both downstream latches match an unresolved ALU operand, the execute/memory result is chosen.
- R4: When only the memory/writeback latch matches an unresolved ALU operand, its result is chosen and resolved=1.
- R5: An operand entering with resolved=1 leaves with its own value and resolved=1, whatever the producers hold.
- R6: An unresolved operand with no matching producer leaves with its incoming value and resolved=0.
- R7: An operand with index 0 is never filled by forwarding, even when a producer's destination is 0.
- R8: A latch that is empty, or holds an instruction that writes no register, never supplies a value.
- R9: The unresolved store-data operand is filled only from the memory/writeback latch; a matching execute/memory latch has no effect on it.
- R10: A forwarded result of zero is delivered with resolved=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | RW | First ALU operand register index |
| src_a_val | input | DW | First ALU operand incoming value |
| src_a_ok | input | 1 | First ALU operand already resolved |
| src_b_idx | input | RW | Second ALU operand register index |
| src_b_val | input | DW | Second ALU operand incoming value |
| src_b_ok | input | 1 | Second ALU operand already resolved |
| sd_idx | input | RW | Store-data operand index (execute/memory latch) |
| sd_val | input | DW | Store-data operand incoming value |
| sd_ok | input | 1 | Store-data operand already resolved |
| xm_full | input | 1 | Execute/memory latch occupied |
| xm_wr | input | 1 | Execute/memory instruction writes a register |
| xm_dst | input | RW | Execute/memory destination index |
| xm_res | input | DW | Execute/memory result |
| mw_full | input | 1 | Memory/writeback latch occupied |
| mw_wr | input | 1 | Memory/writeback instruction writes a register |
| mw_dst | input | RW | Memory/writeback destination index |
| mw_res | input | DW | Memory/writeback result |
| src_a_fval | output | DW | First ALU operand outgoing value |
| src_a_fok | output | 1 | First ALU operand outgoing resolved flag |
| src_b_fval | output | DW | Second ALU operand outgoing value |
| src_b_fok | output | 1 | Second ALU operand outgoing resolved flag |
| sd_fval | output | DW | Store-data outgoing value |
| sd_fok | output | 1 | Store-data outgoing resolved flag |

## Verification
Whenever the inputs change, the assertions check several rules. Resolved operands stay untouched. Index 0 is never filled. The resolved flag never drops. An execute/memory hit wins for ALU operands. The store path takes only the memory/writeback result. Only the directed scenarios can show the cases where nothing matches. They also cover empty or non-writing latches, the forwarding of a zero result, and the independence of the two ALU operands, where the expected result depends on which producer should have been ignored.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  // producer slots, listed in priority order (lower index wins)
  localparam int SRC_XM   = 0;
  localparam int SRC_MW   = 1;
  localparam int ALU_NSRC = 2;
  // ALU operand slots
  localparam int OPN_A    = 0;
  localparam int OPN_B    = 1;
  localparam int ALU_NOPN = 2;
endpackage

// File: rtl/opnd_bypass_match.sv
module opnd_bypass_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] want_idx,
  input  logic          want_ok,
  input  logic          prod_full,
  input  logic          prod_wr,
  input  logic [RW-1:0] prod_dst,
  output logic          hit
);
  logic idx_eq;
  logic idx_zero;

  assign idx_eq   = (prod_dst == want_idx);
  assign idx_zero = (want_idx == '0);
  assign hit      = !want_ok && prod_full && prod_wr && idx_eq && !idx_zero;
endmodule

// File: rtl/opnd_bypass_pick.sv
module opnd_bypass_pick #(
  parameter int DW   = 32,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0]    hits,
  input  logic [NSRC*DW-1:0] vals,
  input  logic [DW-1:0]      in_val,
  input  logic               in_ok,
  output logic [DW-1:0]      out_val,
  output logic               out_ok
);
  always_comb begin
    out_val = in_val;
    out_ok  = in_ok;
    // walk from lowest priority to highest so the highest hit lands last
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (hits[s]) begin
        out_val = vals[s*DW +: DW];
        out_ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] src_a_idx,
  input  logic [DW-1:0] src_a_val,
  input  logic          src_a_ok,
  input  logic [RW-1:0] src_b_idx,
  input  logic [DW-1:0] src_b_val,
  input  logic          src_b_ok,
  input  logic [RW-1:0] sd_idx,
  input  logic [DW-1:0] sd_val,
  input  logic          sd_ok,
  input  logic          xm_full,
  input  logic          xm_wr,
  input  logic [RW-1:0] xm_dst,
  input  logic [DW-1:0] xm_res,
  input  logic          mw_full,
  input  logic          mw_wr,
  input  logic [RW-1:0] mw_dst,
  input  logic [DW-1:0] mw_res,
  output logic [DW-1:0] src_a_fval,
  output logic          src_a_fok,
  output logic [DW-1:0] src_b_fval,
  output logic          src_b_fok,
  output logic [DW-1:0] sd_fval,
  output logic          sd_fok
);
  localparam int VBUS = ALU_NSRC * DW;

  // producers gathered in priority order
  logic [ALU_NSRC-1:0]   p_full, p_wr;
  logic [RW-1:0]         p_dst [ALU_NSRC];
  logic [VBUS-1:0]       p_vals;

  assign p_full[SRC_XM] = xm_full;
  assign p_full[SRC_MW] = mw_full;
  assign p_wr[SRC_XM]   = xm_wr;
  assign p_wr[SRC_MW]   = mw_wr;
  assign p_dst[SRC_XM]  = xm_dst;
  assign p_dst[SRC_MW]  = mw_dst;
  assign p_vals[SRC_XM*DW +: DW] = xm_res;
  assign p_vals[SRC_MW*DW +: DW] = mw_res;

  // ALU operands gathered as arrays
  logic [RW-1:0] o_idx  [ALU_NOPN];
  logic [DW-1:0] o_val  [ALU_NOPN];
  logic          o_ok   [ALU_NOPN];
  logic [DW-1:0] o_fval [ALU_NOPN];
  logic          o_fok  [ALU_NOPN];

  assign o_idx[OPN_A] = src_a_idx;
  assign o_val[OPN_A] = src_a_val;
  assign o_ok[OPN_A]  = src_a_ok;
  assign o_idx[OPN_B] = src_b_idx;
  assign o_val[OPN_B] = src_b_val;
  assign o_ok[OPN_B]  = src_b_ok;

  for (genvar o = 0; o < ALU_NOPN; o++) begin : g_alu
    logic [ALU_NSRC-1:0] hits;
    for (genvar s = 0; s < ALU_NSRC; s++) begin : g_src
      opnd_bypass_match #(.RW(RW)) u_match (
        .want_idx  (o_idx[o]),
        .want_ok   (o_ok[o]),
        .prod_full (p_full[s]),
        .prod_wr   (p_wr[s]),
        .prod_dst  (p_dst[s]),
        .hit       (hits[s])
      );
    end
    opnd_bypass_pick #(.DW(DW), .NSRC(ALU_NSRC)) u_pick (
      .hits    (hits),
      .vals    (p_vals),
      .in_val  (o_val[o]),
      .in_ok   (o_ok[o]),
      .out_val (o_fval[o]),
      .out_ok  (o_fok[o])
    );
  end

  assign src_a_fval = o_fval[OPN_A];
  assign src_a_fok  = o_fok[OPN_A];
  assign src_b_fval = o_fval[OPN_B];
  assign src_b_fok  = o_fok[OPN_B];

  // store-data path: memory/writeback producer only
  logic [0:0] sd_hit;

  opnd_bypass_match #(.RW(RW)) u_sd_match (
    .want_idx  (sd_idx),
    .want_ok   (sd_ok),
    .prod_full (mw_full),
    .prod_wr   (mw_wr),
    .prod_dst  (mw_dst),
    .hit       (sd_hit[0])
  );

  opnd_bypass_pick #(.DW(DW), .NSRC(1)) u_sd_pick (
    .hits    (sd_hit),
    .vals    (mw_res),
    .in_val  (sd_val),
    .in_ok   (sd_ok),
    .out_val (sd_fval),
    .out_ok  (sd_fok)
  );
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input logic [RW-1:0] src_a_idx,
  input logic [DW-1:0] src_a_val,
  input logic          src_a_ok,
  input logic [RW-1:0] src_b_idx,
  input logic          src_b_ok,
  input logic [RW-1:0] sd_idx,
  input logic          sd_ok,
  input logic          xm_full,
  input logic          xm_wr,
  input logic [RW-1:0] xm_dst,
  input logic [DW-1:0] xm_res,
  input logic [DW-1:0] mw_res,
  input logic [DW-1:0] src_a_fval,
  input logic          src_a_fok,
  input logic          src_b_fok,
  input logic [DW-1:0] sd_fval,
  input logic          sd_fok
);
  always_comb begin
    // R5: resolved operand keeps its value
    p_keep_resolved_r5: assert (!src_a_ok || (src_a_fok && src_a_fval == src_a_val))
      else $error("resolved operand altered");
    // R5: the flag never drops
    p_flag_hold_r5: assert ((!src_b_ok || src_b_fok) && (!sd_ok || sd_fok))
      else $error("resolved flag dropped");
    // R7: index 0 is never filled
    p_no_zero_reg_r7: assert (!((src_a_idx == '0) && !src_a_ok && src_a_fok) &&
                              !((src_b_idx == '0) && !src_b_ok && src_b_fok) &&
                              !((sd_idx == '0) && !sd_ok && sd_fok))
      else $error("register 0 forwarded");
    // R3: execute/memory hit wins for an ALU operand
    p_xm_priority_r3: assert (!(!src_a_ok && xm_full && xm_wr && xm_dst == src_a_idx &&
                                src_a_idx != '0) || (src_a_fok && src_a_fval == xm_res))
      else $error("execute/memory result not chosen");
    // R9: store data only ever takes the memory/writeback result
    p_store_src_r9: assert (!(!sd_ok && sd_fok) || sd_fval == mw_res)
      else $error("store data from wrong producer");
  end
endmodule

bind opnd_bypass opnd_bypass_chk #(.RW(RW), .DW(DW)) u_chk (
  .src_a_idx  (src_a_idx),
  .src_a_val  (src_a_val),
  .src_a_ok   (src_a_ok),
  .src_b_idx  (src_b_idx),
  .src_b_ok   (src_b_ok),
  .sd_idx     (sd_idx),
  .sd_ok      (sd_ok),
  .xm_full    (xm_full),
  .xm_wr      (xm_wr),
  .xm_dst     (xm_dst),
  .xm_res     (xm_res),
  .mw_res     (mw_res),
  .src_a_fval (src_a_fval),
  .src_a_fok  (src_a_fok),
  .src_b_fok  (src_b_fok),
  .sd_fval    (sd_fval),
  .sd_fok     (sd_fok)
);

// File: tb/opnd_bypass_tb.sv
module opnd_bypass_tb;
  localparam int RW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [RW-1:0] src_a_idx, src_b_idx, sd_idx, xm_dst, mw_dst;
  logic [DW-1:0] src_a_val, src_b_val, sd_val, xm_res, mw_res;
  logic          src_a_ok, src_b_ok, sd_ok, xm_full, xm_wr, mw_full, mw_wr;
  logic [DW-1:0] src_a_fval, src_b_fval, sd_fval;
  logic          src_a_fok, src_b_fok, sd_fok;

  int n_run = 0;
  int n_fail = 0;
  logic rst_n = 1'b0;

  opnd_bypass #(.RW(RW), .DW(DW)) u_dut (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    src_a_idx = 5'd1; src_a_val = 32'hA0; src_a_ok = 1'b0;
    src_b_idx = 5'd2; src_b_val = 32'hB0; src_b_ok = 1'b0;
    sd_idx    = 5'd3; sd_val    = 32'hC0; sd_ok    = 1'b0;
    xm_full = 1'b0; xm_wr = 1'b0; xm_dst = 5'd0; xm_res = 32'h0;
    mw_full = 1'b0; mw_wr = 1'b0; mw_dst = 5'd0; mw_res = 32'h0;
  endtask

  task automatic settle();
    #5;
  endtask

  task automatic t_reset_state();
    idle(); settle();
    chk("R6 a ok", {31'd0, src_a_fok}, 32'd0);
    chk("R6 a val", src_a_fval, 32'hA0);
    chk("R6 b ok", {31'd0, src_b_fok}, 32'd0);
    chk("R6 sd ok", {31'd0, sd_fok}, 32'd0);
  endtask

  task automatic t_xm_fwd();
    idle(); xm_full = 1; xm_wr = 1; xm_dst = 5'd1; xm_res = 32'h1234; settle();
    chk("R1 a val", src_a_fval, 32'h1234);
    chk("R1 a ok", {31'd0, src_a_fok}, 32'd1);
    chk("R2 b untouched", {31'd0, src_b_fok}, 32'd0);
    chk("R9 sd ignores xm", {31'd0, sd_fok}, 32'd0);
    xm_dst = 5'd2; settle();
    chk("R2 b val", src_b_fval, 32'h1234);
    chk("R2 a no match", {31'd0, src_a_fok}, 32'd0);
    xm_dst = 5'd3; settle();
    chk("R9 sd xm match ignored", sd_fval, 32'hC0);
  endtask

  task automatic t_priority();
    idle(); xm_full = 1; xm_wr = 1; xm_dst = 5'd1; xm_res = 32'h11;
    mw_full = 1; mw_wr = 1; mw_dst = 5'd1; mw_res = 32'h22; settle();
    chk("R3 xm wins", src_a_fval, 32'h11);
    xm_dst = 5'd9; settle();
    chk("R4 mw chosen", src_a_fval, 32'h22);
    chk("R4 mw ok", {31'd0, src_a_fok}, 32'd1);
  endtask

  task automatic t_resolved();
    idle(); src_a_ok = 1; src_b_ok = 1; sd_ok = 1;
    xm_full = 1; xm_wr = 1; xm_dst = 5'd1; xm_res = 32'h55;
    mw_full = 1; mw_wr = 1; mw_dst = 5'd3; mw_res = 32'h66; settle();
    chk("R5 a kept", src_a_fval, 32'hA0);
    chk("R5 sd kept", sd_fval, 32'hC0);
    chk("R5 sd ok", {31'd0, sd_fok}, 32'd1);
  endtask

  task automatic t_zero_reg();
    idle(); src_a_idx = 5'd0; sd_idx = 5'd0;
    xm_full = 1; xm_wr = 1; xm_dst = 5'd0; xm_res = 32'h77;
    mw_full = 1; mw_wr = 1; mw_dst = 5'd0; mw_res = 32'h88; settle();
    chk("R7 a ok", {31'd0, src_a_fok}, 32'd0);
    chk("R7 a val", src_a_fval, 32'hA0);
    chk("R7 sd ok", {31'd0, sd_fok}, 32'd0);
  endtask

  task automatic t_gating();
    idle(); xm_full = 0; xm_wr = 1; xm_dst = 5'd1; xm_res = 32'h99;
    mw_full = 1; mw_wr = 0; mw_dst = 5'd1; mw_res = 32'hAA; settle();
    chk("R8 empty/no-write ok", {31'd0, src_a_fok}, 32'd0);
    chk("R8 empty/no-write val", src_a_fval, 32'hA0);
    mw_wr = 1; settle();
    chk("R8 mw now valid", src_a_fval, 32'hAA);
  endtask

  task automatic t_zero_value();
    idle(); mw_full = 1; mw_wr = 1; mw_dst = 5'd3; mw_res = 32'h0; settle();
    chk("R10 sd zero val", sd_fval, 32'h0);
    chk("R10 sd zero ok", {31'd0, sd_fok}, 32'd1);
    chk("R9 sd from mw", {31'd0, sd_fok}, 32'd1);
    xm_full = 1; xm_wr = 1; xm_dst = 5'd2; xm_res = 32'h0; settle();
    chk("R10 b zero ok", {31'd0, src_b_fok}, 32'd1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_xm_fwd();
    t_priority();
    t_resolved();
    t_zero_reg();
    t_gating();
    t_zero_value();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule